// File: doc/BRIEF.md
# Single-Channel Memory Move Engine

This block is one channel of a direct memory move controller. Software programs a source address, a destination address, a unit count and a control word, then the channel waits for a start condition. The start can be a rising edge or a high level on a trigger input, or a software request bit. Each unit is a read on a simple memory bus, a write of the returned data and one idle cycle. Units can be bytes or 16-bit words, and each side picks its own unit size and address stepping.

The control word picks one of six move modes. In single mode each start moves one unit. In block mode one start moves the whole count. In burst mode the whole count is moved, but the bus goes idle for an extra cycle after every group of units. The repeated forms of these modes stay enabled after the count runs out and rewind the addresses. The count register steps down once per unit. When it runs out it raises a sticky done flag and reloads its programmed value at once. A one-cycle acknowledge tells the trigger source that a start was taken. When abort priority is enabled, a non-maskable interrupt stops the channel at the next unit boundary.

Top module: `dmac_channel`

## Requirements
- R1: Control field `mode` (bits 7:5) = 000 moves exactly one unit per accepted start. Each start drives `trig_ack` high for exactly one cycle, and that cycle is followed by a bus read.
- R2: Mode 001 moves the whole programmed count on one start. When the count runs out, the non-repeated modes (000, 001, 010, 011) clear the enable bit (bit 0) and set the done flag (bit 3, also on `done_flag`).
- R3: Modes 010 and 011 move the whole count on one start. After every fourth unit they insert one extra idle bus cycle, so the distance between two reads grows from 3 cycles to 4.
- R4: Modes 100 to 111 work like their non-repeated forms but keep the enable bit set when the count runs out. They also reload both addresses with the values last written by software, so the next start repeats the same addresses.
- R5: The source step field (bits 9:8) and the destination step field (bits 11:10) mean the following: 00 and 01 keep the address fixed, 10 decrements it and 11 increments it after each unit. The step is 1 for byte units and 2 for word units.
- R6: The source byte bit (bit 12) and the destination byte bit (bit 13) set each side's unit size. Whenever either bit is set, the written data is the low byte of the read data with the upper byte forced to zero. With both bits clear, the full word is copied.
- R7: The count register (select 3) decreases by one per unit. At the unit that brings it to zero it instead reloads the programmed count, and the done flag is set.
- R8: With the level bit (bit 2) clear, one rising edge of `trig_in` gives one start, however long the input stays high. With the level bit set, a new start is taken after each unit for as long as `trig_in` stays high.
- R9: Writing the request bit (bit 1) together with the enable bit starts the channel without a trigger. The request bit reads back 0 once the start is taken.
- R10: Each unit reads the source in one cycle and writes the destination in the next cycle. The cycle after the write has no bus access.
- R11: After reset the control and count registers read zero. Address registers read with bits 31:20 at zero. A write with `cfg_long` = 1 loads bits 19:0. A write with `cfg_long` = 0 loads bits 15:0 and clears bits 19:16.
- R12: With `nmi_pri_en` high, `nmi_in` high at a unit boundary stops the channel before its next read, clears the enable bit and sets the abort bit (bit 4). With `nmi_pri_en` low, `nmi_in` has no effect.
- R13: A trigger edge seen while the enable bit is clear is dropped. It does not start a move later when the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_long | input | 1 | 1 = write all 20 address bits, 0 = write low 16 bits and clear the rest |
| cfg_wdata | input | 20 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| trig_in | input | 1 | Asynchronous trigger from the request source |
| trig_ack | output | 1 | One-cycle pulse when a start is taken |
| nmi_in | input | 1 | Non-maskable interrupt request |
| nmi_pri_en | input | 1 | Lets `nmi_in` abort a move |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_byte | output | 1 | Current access is a byte |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Read data, valid the cycle after `bus_rd` |
| done_flag | output | 1 | Sticky count-exhausted flag |

## Verification
The assertions take two things for granted. Read data returns exactly one cycle after the read strobe, and software does not rewrite the control register in the cycle a unit finishes. The bench memory model answers every read on the following edge. All register writes happen while the channel is idle, so the step, reload and enable checks never see a software write collide with a unit. `nmi_in` is raised only once the bus has shown a known write, so the abort point falls on a defined unit boundary.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_WAIT,
      ST_GAP
   } dmac_state_e;

   localparam int unsigned CTL_W = 14;

   localparam logic [1:0] SEL_CTL  = 2'd0;
   localparam logic [1:0] SEL_SRC  = 2'd1;
   localparam logic [1:0] SEL_DST  = 2'd2;
   localparam logic [1:0] SEL_SIZE = 2'd3;

   localparam logic [1:0] STEP_DOWN = 2'b10;
   localparam logic [1:0] STEP_UP   = 2'b11;

   typedef struct packed {
      logic       dst_byte;
      logic       src_byte;
      logic [1:0] dst_step;
      logic [1:0] src_step;
      logic [2:0] mode;
      logic       abort;
      logic       flag;
      logic       level;
      logic       req;
      logic       en;
   } dmac_ctl_t;

   function automatic logic mode_repeats(input logic [2:0] m);
      return m[2];
   endfunction

   function automatic logic mode_single(input logic [2:0] m);
      return m[1:0] == 2'b00;
   endfunction

   function automatic logic mode_burst(input logic [2:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/dmac_trig_sync.sv
module dmac_trig_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic level_mode,
   input  logic enable,
   input  logic consume,
   output logic pending
);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("dmac_trig_sync: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   edge_pend_q;
   logic                   synced;
   logic                   rise;

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= trig_in;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];
   assign rise   = synced && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q      <= 1'b0;
         edge_pend_q <= 1'b0;
      end else begin
         prev_q <= synced;
         if (!enable)      edge_pend_q <= 1'b0;
         else if (rise)    edge_pend_q <= 1'b1;
         else if (consume) edge_pend_q <= 1'b0;
      end
   end

   assign pending = level_mode ? synced : edge_pend_q;

   // R13: an edge latched while disabled never survives into the enabled state
   a_r13_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !edge_pend_q);

   // R8: a taken start with no fresh edge leaves nothing pending in edge mode
   a_r8_edge_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && consume && !rise) |=> !edge_pend_q);

endmodule

// File: rtl/dmac_addr_reg.sv
module dmac_addr_reg
   import dmac_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned SHORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_long,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_en,
   input  logic [1:0]        step_code,
   input  logic              byte_unit,
   input  logic              rewind,
   output logic [ADDR_W-1:0] cur
);

   if (SHORT_W >= ADDR_W) begin : g_bad_short
      $error("dmac_addr_reg: SHORT_W must be below ADDR_W");
   end

   localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(2);

   logic [ADDR_W-1:0] init_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] wval;
   logic [ADDR_W-1:0] step;

   assign wval = load_long ? load_val : {{(ADDR_W-SHORT_W){1'b0}}, load_val[SHORT_W-1:0]};
   assign step = byte_unit ? STEP_B : STEP_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         init_q <= wval;
         cur_q  <= wval;
      end else if (rewind) begin
         cur_q <= init_q;
      end else if (step_en) begin
         unique case (step_code)
            STEP_UP:   cur_q <= cur_q + step;
            STEP_DOWN: cur_q <= cur_q - step;
            default:   cur_q <= cur_q;
         endcase
      end
   end

   assign cur = cur_q;

   // R5: the fixed codes hold the address across a unit
   a_r5_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load && !rewind && !step_code[1]) |=> $stable(cur_q));

   // R4: a rewind lands on the last software-written value
   a_r4_rewind_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !load) |=> (cur_q == init_q));

endmodule

// File: rtl/dmac_size_ctr.sv
module dmac_size_ctr #(
   parameter int unsigned SIZE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SIZE_W-1:0] load_val,
   input  logic              dec,
   output logic [SIZE_W-1:0] cnt,
   output logic              hit
);

   if (SIZE_W < 2) begin : g_bad_size
      $error("dmac_size_ctr: SIZE_W must be at least 2");
   end

   localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

   logic [SIZE_W-1:0] init_q;
   logic [SIZE_W-1:0] cnt_q;

   assign hit = dec && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         init_q <= load_val;
         cnt_q  <= load_val;
      end else if (dec) begin
         cnt_q <= (cnt_q == ONE) ? init_q : cnt_q - ONE;
      end
   end

   assign cnt = cnt_q;

   // R7: running out reloads the programmed count in the same step
   a_r7_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q == ONE) |=> (cnt_q == init_q));

   // R7: any other unit lowers the count by one
   a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
   import dmac_pkg::*;
#(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned SIZE_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned REG_W       = 32,
   parameter int unsigned BURST_LEN   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic              cfg_long,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              trig_in,
   output logic              trig_ack,
   input  logic              nmi_in,
   input  logic              nmi_pri_en,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_byte,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done_flag
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned BCNT_W = (BURST_LEN < 2) ? 1 : $clog2(BURST_LEN + 1);
   localparam logic [BCNT_W-1:0] BURST_TOP = BCNT_W'(BURST_LEN);

   if (DATA_W != 16) begin : g_bad_data
      $error("dmac_channel: DATA_W must be 16");
   end
   if (ADDR_W <= 16 || ADDR_W > REG_W) begin : g_bad_addr
      $error("dmac_channel: ADDR_W must lie in 17..REG_W");
   end
   if (SIZE_W > ADDR_W || CTL_W > ADDR_W) begin : g_bad_fields
      $error("dmac_channel: count and control must fit the write port");
   end
   if (BURST_LEN < 1) begin : g_bad_burst
      $error("dmac_channel: BURST_LEN must be at least 1");
   end

   dmac_ctl_t         ctl_q;
   dmac_state_e       state_q;
   dmac_state_e       state_d;
   logic [BCNT_W-1:0] burst_q;
   logic              last_q;
   logic [ADDR_W-1:0] src_cur;
   logic [ADDR_W-1:0] dst_cur;
   logic [SIZE_W-1:0] cnt;
   logic              cnt_hit;
   logic              trig_pend;
   logic              wr_ctl;
   logic              wr_src;
   logic              wr_dst;
   logic              wr_size;
   logic              start;
   logic              in_write;
   logic              at_boundary;
   logic              nmi_hit;
   logic              is_repeat;
   logic              is_single;
   logic              is_burst;
   logic              burst_full;
   logic              rewind;
   logic              narrow;

   assign wr_ctl  = cfg_we && (cfg_sel == SEL_CTL);
   assign wr_src  = cfg_we && (cfg_sel == SEL_SRC);
   assign wr_dst  = cfg_we && (cfg_sel == SEL_DST);
   assign wr_size = cfg_we && (cfg_sel == SEL_SIZE);

   assign is_repeat  = mode_repeats(ctl_q.mode);
   assign is_single  = mode_single(ctl_q.mode);
   assign is_burst   = mode_burst(ctl_q.mode);
   assign burst_full = (burst_q == BURST_TOP);

   assign in_write    = (state_q == ST_WRITE);
   assign at_boundary = (state_q == ST_WAIT) || (state_q == ST_GAP);
   assign nmi_hit     = nmi_pri_en && nmi_in && at_boundary;
   assign start       = (state_q == ST_IDLE) && ctl_q.en && (trig_pend || ctl_q.req) && !wr_ctl;
   assign rewind      = in_write && cnt_hit && is_repeat;

   dmac_trig_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) trig_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_in    (trig_in),
      .level_mode (ctl_q.level),
      .enable     (ctl_q.en),
      .consume    (start),
      .pending    (trig_pend)
   );

   dmac_addr_reg #(
      .ADDR_W (ADDR_W)
   ) src_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_src),
      .load_long (cfg_long),
      .load_val  (cfg_wdata),
      .step_en   (in_write),
      .step_code (ctl_q.src_step),
      .byte_unit (ctl_q.src_byte),
      .rewind    (rewind),
      .cur       (src_cur)
   );

   dmac_addr_reg #(
      .ADDR_W (ADDR_W)
   ) dst_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_dst),
      .load_long (cfg_long),
      .load_val  (cfg_wdata),
      .step_en   (in_write),
      .step_code (ctl_q.dst_step),
      .byte_unit (ctl_q.dst_byte),
      .rewind    (rewind),
      .cur       (dst_cur)
   );

   dmac_size_ctr #(
      .SIZE_W (SIZE_W)
   ) size_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_size),
      .load_val (cfg_wdata[SIZE_W-1:0]),
      .dec      (in_write),
      .cnt      (cnt),
      .hit      (cnt_hit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ST_READ;
         ST_READ:  state_d = ST_WRITE;
         ST_WRITE: state_d = ST_WAIT;
         ST_WAIT: begin
            if (nmi_hit || last_q || is_single || !ctl_q.en) state_d = ST_IDLE;
            else if (is_burst && burst_full)                 state_d = ST_GAP;
            else                                             state_d = ST_READ;
         end
         ST_GAP:   state_d = nmi_hit ? ST_IDLE : ST_READ;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         burst_q <= '0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (in_write) last_q <= cnt_hit;
         if (start)                                 burst_q <= '0;
         else if (in_write)                         burst_q <= burst_q + 1'b1;
         else if (state_q == ST_WAIT && burst_full) burst_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q <= dmac_ctl_t'(cfg_wdata[CTL_W-1:0]);
      end else begin
         if (start) ctl_q.req <= 1'b0;
         if (in_write && cnt_hit) begin
            ctl_q.flag <= 1'b1;
            if (!is_repeat) ctl_q.en <= 1'b0;
         end
         if (nmi_hit) begin
            ctl_q.abort <= 1'b1;
            ctl_q.en    <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (cfg_sel)
         SEL_CTL:  cfg_rdata = REG_W'(ctl_q);
         SEL_SRC:  cfg_rdata = REG_W'(src_cur);
         SEL_DST:  cfg_rdata = REG_W'(dst_cur);
         default:  cfg_rdata = REG_W'(cnt);
      endcase
   end

   assign narrow    = ctl_q.src_byte || ctl_q.dst_byte;
   assign trig_ack  = start;
   assign bus_rd    = (state_q == ST_READ);
   assign bus_wr    = in_write;
   assign bus_addr  = in_write ? dst_cur : src_cur;
   assign bus_byte  = in_write ? ctl_q.dst_byte : ctl_q.src_byte;
   assign bus_wdata = narrow ? {{HALF_W{1'b0}}, bus_rdata[HALF_W-1:0]} : bus_rdata;
   assign done_flag = ctl_q.flag;

   // R10: a read is always followed by the matching write
   a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_wr);

   // R10: the cycle after a write is quiet on the bus
   a_r10_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (!bus_rd && !bus_wr));

   // R1: the acknowledge is a single-cycle pulse
   a_r1_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      trig_ack |=> !trig_ack);

   // R1: every acknowledge opens a unit with a read
   a_r1_ack_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      trig_ack |=> bus_rd);

   // R12: an abort at a boundary issues no further read
   a_r12_abort_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pri_en && nmi_in && at_boundary) |=> (!bus_rd && !ctl_q.en));

   // R2: a non-repeated mode disables itself when the count runs out
   a_r2_end_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (in_write && cnt_hit && !is_repeat && !wr_ctl) |=> !ctl_q.en);

   // R4: a repeated mode stays enabled when the count runs out
   a_r4_repeat_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
      (in_write && cnt_hit && is_repeat && ctl_q.en && !wr_ctl) |=> ctl_q.en);

endmodule

// File: tb/dmac_channel_tb.sv
`timescale 1ns/1ps
module dmac_channel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic        cfg_long = 1'b1;
   logic [19:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        trig_in = 1'b0;
   logic        trig_ack;
   logic        nmi_in = 1'b0;
   logic        nmi_pri_en = 1'b0;
   logic        bus_rd, bus_wr, bus_byte;
   logic [19:0] bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        done_flag;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int ack_n = 0;
   int wr_n = 0;
   logic prev_rd = 1'b0;
   logic after_wr = 1'b0;
   logic [36:0] exp_q[$];
   int rd_cyc[$];
   logic [19:0] m_src, m_dst;

   always #10 clk = ~clk;

   dmac_channel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_long(cfg_long), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .trig_in(trig_in), .trig_ack(trig_ack), .nmi_in(nmi_in),
      .nmi_pri_en(nmi_pri_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .done_flag(done_flag)
   );

   function automatic logic [15:0] mem(input logic [19:0] a);
      return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
   endfunction

   function automatic logic [19:0] adv(input logic [19:0] a, input logic [1:0] code, input logic byt);
      if (code == 2'b11) return a + (byt ? 20'd1 : 20'd2);
      if (code == 2'b10) return a - (byt ? 20'd1 : 20'd2);
      return a;
   endfunction

   // control word: 13 dst byte, 12 src byte, 11:10 dst step, 9:8 src step,
   // 7:5 mode, 4 abort, 3 flag, 2 level, 1 request, 0 enable
   function automatic logic [19:0] mk_ctl(input logic [2:0] mode, input logic [1:0] ss,
                                          input logic [1:0] ds, input logic sb, input logic db,
                                          input logic lvl, input logic req, input logic en);
      return {6'd0, db, sb, ds, ss, mode, 1'b0, 1'b0, lvl, req, en};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [36:0] act, input logic [36:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (bus_rd) bus_rdata <= mem(bus_addr);
   end

   // monitor: pops the scoreboard on every bus write
   always @(negedge clk) begin
      if (rst_n) begin
         if (trig_ack) ack_n++;
         if (bus_rd) rd_cyc.push_back(cyc);
         if (after_wr) chk(!bus_rd && !bus_wr, "R10 idle after write", {35'd0, bus_rd, bus_wr}, 37'd0);
         if (bus_wr) begin
            wr_n++;
            chk(prev_rd, "R10 read precedes write", {36'd0, prev_rd}, 37'd1);
            if (exp_q.size() == 0) chk(1'b0, "R5 R6 unexpected write", {bus_addr, bus_wdata, bus_byte}, 37'd0);
            else begin
               logic [36:0] e;
               e = exp_q.pop_front();
               chk({bus_addr, bus_wdata, bus_byte} == e, "R5 R6 write content",
                   {bus_addr, bus_wdata, bus_byte}, e);
            end
         end
         after_wr = bus_wr;
         prev_rd = bus_rd;
      end
   end

   // driver: pushes expected writes for n units
   task automatic push_units(input int n, input logic [1:0] ss, input logic [1:0] ds,
                             input logic sb, input logic db);
      for (int i = 0; i < n; i++) begin
         logic [15:0] d;
         d = (sb || db) ? {8'h00, mem(m_src)[7:0]} : mem(m_src);
         exp_q.push_back({m_dst, d, db});
         m_src = adv(m_src, ss, sb);
         m_dst = adv(m_dst, ds, db);
      end
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [19:0] v, input logic lng);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v; cfg_long = lng;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [31:0] v);
      @(negedge clk);
      cfg_sel = s;
      #1 v = cfg_rdata;
   endtask

   task automatic setup(input logic [19:0] s, input logic [19:0] d, input logic [15:0] n, input logic [19:0] c);
      wr_reg(2'd1, s, 1'b1);
      wr_reg(2'd2, d, 1'b1);
      wr_reg(2'd3, {4'd0, n}, 1'b1);
      wr_reg(2'd0, c, 1'b1);
      m_src = s; m_dst = d;
      ack_n = 0; rd_cyc.delete();
   endtask

   task automatic pulse(input int hold);
      @(negedge clk); trig_in = 1'b1;
      repeat (hold) @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_drained(input string req);
      chk(exp_q.size() == 0, req, 37'(exp_q.size()), 37'd0);
   endtask

   task automatic chk_spacing(input logic burst, input string req);
      for (int i = 1; i < rd_cyc.size(); i++) begin
         int e;
         e = (burst && (i % 4 == 0)) ? 4 : 3;
         chk(rd_cyc[i] - rd_cyc[i-1] == e, req, 37'(rd_cyc[i] - rd_cyc[i-1]), 37'(e));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R11: reset state
      rd_reg(2'd0, v); chk(v == 0, "R11 control after reset", 37'(v), 37'd0);
      rd_reg(2'd3, v); chk(v == 0, "R11 count after reset", 37'(v), 37'd0);
      chk(!done_flag && !bus_rd && !bus_wr, "R11 outputs after reset", {34'd0, done_flag, bus_rd, bus_wr}, 37'd0);

      // R11: address width handling
      wr_reg(2'd1, 20'hFABCD, 1'b1);
      rd_reg(2'd1, v); chk(v == 32'h000FABCD, "R11 long address write", 37'(v), 37'h0FABCD);
      wr_reg(2'd1, 20'hF1234, 1'b0);
      rd_reg(2'd1, v); chk(v == 32'h00001234, "R11 short write clears 19:16", 37'(v), 37'h01234);

      // R1 R8: single mode, edge trigger held high gives one unit each
      setup(20'h00100, 20'h02000, 16'd3, mk_ctl(3'b000, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      push_units(1, 2'b11, 2'b00, 1'b0, 1'b0);
      pulse(6); idle(20);
      chk_drained("R8 one unit per edge");
      chk(ack_n == 1, "R1 one ack per start", 37'(ack_n), 37'd1);
      rd_reg(2'd3, v); chk(v == 2, "R7 count steps down", 37'(v), 37'd2);
      push_units(2, 2'b11, 2'b00, 1'b0, 1'b0);
      pulse(2); idle(20); pulse(2); idle(20);
      chk_drained("R1 single mode units");
      chk(ack_n == 3, "R1 ack count", 37'(ack_n), 37'd3);
      rd_reg(2'd3, v); chk(v == 3, "R7 count reloads at zero", 37'(v), 37'd3);
      rd_reg(2'd0, v); chk(v[3] && !v[0], "R2 flag set and enable cleared", 37'(v[3:0]), 37'h8);

      // R13: edge while disabled is dropped
      setup(20'h00100, 20'h02000, 16'd2, mk_ctl(3'b000, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      base = wr_n;
      pulse(3); idle(10);
      wr_reg(2'd0, mk_ctl(3'b000, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1), 1'b1);
      idle(20);
      chk(wr_n == base && ack_n == 0, "R13 disabled trigger ignored", 37'(wr_n - base), 37'd0);

      // R2 R5 R6: block mode, byte source stepping down into fixed... word destination stepping up
      setup(20'h00310, 20'h00400, 16'd5, mk_ctl(3'b001, 2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
      push_units(5, 2'b10, 2'b11, 1'b1, 1'b0);
      pulse(2); idle(40);
      chk_drained("R2 whole block on one start");
      chk(ack_n == 1, "R2 one ack per block", 37'(ack_n), 37'd1);
      chk(done_flag, "R2 done flag", {36'd0, done_flag}, 37'd1);
      chk_spacing(1'b0, "R10 unit spacing");
      rd_reg(2'd1, v); chk(v == 32'h0030B, "R5 byte decrement final source", 37'(v), 37'h0030B);

      // R3 R6: burst mode, word source into byte destination
      setup(20'h01000, 20'h05000, 16'd10, mk_ctl(3'b010, 2'b11, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
      push_units(10, 2'b11, 2'b11, 1'b0, 1'b1);
      pulse(2); idle(60);
      chk_drained("R3 burst block complete");
      chk(rd_cyc.size() == 10, "R3 read count", 37'(rd_cyc.size()), 37'd10);
      chk_spacing(1'b1, "R3 gap after every fourth unit");

      // R4 R5: repeated block, fixed destination code 01
      setup(20'h00200, 20'h03000, 16'd3, mk_ctl(3'b101, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      push_units(3, 2'b11, 2'b01, 1'b0, 1'b0);
      pulse(2); idle(30);
      chk_drained("R4 first pass");
      rd_reg(2'd0, v); chk(v[0] && v[3], "R4 enable kept", 37'(v[3:0]), 37'h9);
      rd_reg(2'd1, v); chk(v == 32'h200, "R4 source rewound", 37'(v), 37'h200);
      m_src = 20'h00200; m_dst = 20'h03000;
      push_units(3, 2'b11, 2'b01, 1'b0, 1'b0);
      pulse(2); idle(30);
      chk_drained("R4 second pass repeats addresses");

      // R8: level trigger restarts while high
      setup(20'h00500, 20'h00600, 16'd3, mk_ctl(3'b000, 2'b11, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
      push_units(3, 2'b11, 2'b11, 1'b0, 1'b0);
      pulse(60); idle(10);
      chk_drained("R8 level restarts");
      chk(ack_n == 3, "R8 level ack count", 37'(ack_n), 37'd3);

      // R9: software request
      setup(20'h00700, 20'h00800, 16'd2, mk_ctl(3'b001, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
      push_units(2, 2'b11, 2'b11, 1'b0, 1'b0);
      idle(20);
      chk_drained("R9 request starts block");
      rd_reg(2'd0, v); chk(!v[1] && v[3], "R9 request self-clears", 37'(v[3:0]), 37'h8);

      // R12: abort with priority enabled stops after the third unit
      nmi_pri_en = 1'b1;
      setup(20'h00900, 20'h00A00, 16'd10, mk_ctl(3'b001, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      push_units(3, 2'b11, 2'b11, 1'b0, 1'b0);
      @(negedge clk); trig_in = 1'b1;
      begin
         int seen;
         seen = 0;
         while (seen < 3) begin
            @(negedge clk);
            trig_in = 1'b0;
            if (bus_wr) seen++;
         end
      end
      nmi_in = 1'b1;
      idle(20);
      nmi_in = 1'b0;
      chk_drained("R12 abort stops at boundary");
      rd_reg(2'd0, v); chk(v[4] && !v[0], "R12 abort bit and enable", 37'(v[4:0]), 37'h10);

      // R12: no effect without priority enable
      nmi_pri_en = 1'b0;
      setup(20'h00B00, 20'h00C00, 16'd4, mk_ctl(3'b001, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
      push_units(4, 2'b11, 2'b11, 1'b0, 1'b0);
      nmi_in = 1'b1;
      pulse(2); idle(30);
      nmi_in = 1'b0;
      chk_drained("R12 interrupt ignored when not prioritised");
      rd_reg(2'd0, v); chk(!v[4] && v[3], "R12 no abort bit", 37'(v[4:0]), 37'h08);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule